// File: doc/BRIEF.md
# Dual-Side Mailbox Message Registers

This block passes 32-bit words between two processor sides, called A and B, that share one clock. Each side owns four outbound message slots. A word written into outbound slot n of one side lands in inbound slot n of the other side. Each side sees two flags per slot. One flag says its outbound slot may take a new word. The other says its inbound slot holds a word that has not yet been consumed.

Software on each side uses a plain register interface with an address, a write strobe, a read strobe, write data and read data. Before writing a slot it polls that slot's empty flag in the status register. Before reading a slot it polls that slot's full flag. The flags are kept exact on every cycle. A read of a slot hands the slot back to the sender, and a write fills the peer's slot.

The two directions are fully separate channels. Read data is registered: it appears on the cycle after the read strobe and stays there until the next read.

Top module: `mbx_dual`

## Requirements
- R1: After reset, every outbound-empty flag is 1 and every inbound-full flag is 0 on both sides, and both read-data outputs are 0.
- R2: Each side has four 32-bit slots. Addresses 0 to 3 select slot 0 to 3: a write goes to the outbound slot and a read comes from the inbound slot. Address 4 is the status register.
- R3: A write to outbound slot n on one side stores the word in the peer's inbound slot n. From the next cycle on, the sender's empty flag n is 0 and the peer's full flag n is 1.
- R4: A read of inbound slot n returns the stored word on read data one cycle after the read strobe. From the next cycle on, the reader's full flag n is 0 and the peer's empty flag n is 1.
- R5: In the status word, the outbound-empty flag of slot n is at bit 7-n, the inbound-full flag of slot n is at bit 3-n, and all other bits read 0.
- R6: A write to an outbound slot whose empty flag is 0 replaces the pending word and leaves all flags as they were.
- R7: When a read of inbound slot n and the peer's write to the same slot happen in one cycle, the read returns the old word, the full flag stays 1, and the new word is kept.
- R8: Writes to address 4 or above change no slot and no flag. Reads of addresses 5 to 7 return 0.
- R9: The two directions are independent. A write by one side never changes that side's own inbound flags or words.
- R10: Read data holds its last value while the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_addr | input | 3 | Side A register address |
| a_wr_en | input | 1 | Side A write strobe |
| a_rd_en | input | 1 | Side A read strobe |
| a_wr_data | input | 32 | Side A write data |
| a_rd_data | output | 32 | Side A registered read data |
| b_addr | input | 3 | Side B register address |
| b_wr_en | input | 1 | Side B write strobe |
| b_rd_en | input | 1 | Side B read strobe |
| b_wr_data | input | 32 | Side B write data |
| b_rd_data | output | 32 | Side B registered read data |

## Verification
All state sits in one full bit and one data word per slot and direction. A wrong flag therefore shows up in the status word of both sides on the first status read after the faulty access, which is two cycles after the access. A wrong or lost word shows up only when the receiving side reads that slot, so every fill is followed by a read of the slot and a status poll on both sides. The overwrite, collision and ignored-address cases are each followed by reads that would reveal any change to a slot or flag.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int unsigned MBX_SLOTS_DEF = 4;
    localparam int unsigned MBX_DW_DEF    = 32;

    // kind of register a side address selects
    typedef enum logic [1:0] {
        ACC_SLOT,
        ACC_STAT,
        ACC_VOID
    } acc_e;

    function automatic acc_e classify(input int unsigned a, input int unsigned slots);
        if (a < slots)
            return ACC_SLOT;
        else if (a == slots)
            return ACC_STAT;
        return ACC_VOID;
    endfunction

endpackage

// File: rtl/mbx_channel.sv
// One direction of the mailbox: sender writes slots, receiver consumes them.
module mbx_channel #(
    parameter int unsigned N = 4,
    parameter int unsigned W = 32,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IW-1:0]       wr_idx,
    input  logic [W-1:0]        wr_data,
    input  logic                rd_en,
    input  logic [IW-1:0]       rd_idx,
    output logic [N-1:0][W-1:0] slot_data,
    output logic [N-1:0]        slot_full
);

    typedef struct packed {
        logic [N-1:0][W-1:0] data;
        logic [N-1:0]        full;
    } chan_t;

    chan_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            if (rd_en && rd_idx == IW'(i))
                st_d.full[i] = 1'b0;
            // a write in the same cycle wins over the read
            if (wr_en && wr_idx == IW'(i)) begin
                st_d.full[i] = 1'b1;
                st_d.data[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign slot_data = st_q.data;
    assign slot_full = st_q.full;

    p_write_sets_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> slot_full[$past(wr_idx)]);

    p_read_clears_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !(wr_en && wr_idx == rd_idx)) |=> !slot_full[$past(rd_idx)]);

    p_overwrite_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && slot_full[wr_idx]) |=> (slot_full[$past(wr_idx)] && slot_data[$past(wr_idx)] == $past(wr_data)));

    p_collision_keeps_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en && wr_idx == rd_idx) |=> (slot_full[$past(wr_idx)] && slot_data[$past(wr_idx)] == $past(wr_data)));

    p_full_rises_on_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ((slot_full & ~$past(slot_full)) == '0));

    p_data_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(slot_data));

endmodule

// File: rtl/mbx_side.sv
// Register interface of one side: address decode, status packing, read data.
module mbx_side
    import mbx_pkg::*;
#(
    parameter int unsigned N  = 4,
    parameter int unsigned W  = 32,
    parameter int unsigned AW = 3,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [AW-1:0]       addr,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [W-1:0]        wr_data,
    input  logic [N-1:0][W-1:0] rx_data,
    input  logic [N-1:0]        rx_full,
    input  logic [N-1:0]        tx_full,
    output logic [W-1:0]        rd_data,
    output logic                tx_wr,
    output logic [IW-1:0]       tx_idx,
    output logic [W-1:0]        tx_word,
    output logic                rx_rd,
    output logic [IW-1:0]       rx_idx
);

    typedef struct packed {
        logic [W-1:0] rdata;
    } side_t;

    side_t sd_d, sd_q;
    acc_e  acc;
    logic [W-1:0] stat_word;

    assign acc     = classify(32'(addr), N);
    assign tx_wr   = wr_en && (acc == ACC_SLOT);
    assign rx_rd   = rd_en && (acc == ACC_SLOT);
    assign tx_idx  = addr[IW-1:0];
    assign rx_idx  = addr[IW-1:0];
    assign tx_word = wr_data;

    // slot 0 holds the top bit of each flag group
    always_comb begin
        stat_word = '0;
        for (int n = 0; n < N; n++) begin
            stat_word[2*N-1-n] = ~tx_full[n];
            stat_word[N-1-n]   = rx_full[n];
        end
    end

    always_comb begin
        sd_d = sd_q;
        if (rd_en) begin
            unique case (acc)
                ACC_SLOT: sd_d.rdata = rx_data[rx_idx];
                ACC_STAT: sd_d.rdata = stat_word;
                default:  sd_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            sd_q <= '0;
        else
            sd_q <= sd_d;
    end

    assign rd_data = sd_q.rdata;

    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    p_void_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && 32'(addr) > N) |=> (rd_data == '0));

endmodule

// File: rtl/mbx_dual.sv
module mbx_dual
    import mbx_pkg::*;
#(
    parameter int unsigned N = MBX_SLOTS_DEF,
    parameter int unsigned W = MBX_DW_DEF,
    localparam int unsigned AW = $clog2(N + 1),
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] a_addr,
    input  logic          a_wr_en,
    input  logic          a_rd_en,
    input  logic [W-1:0]  a_wr_data,
    output logic [W-1:0]  a_rd_data,
    input  logic [AW-1:0] b_addr,
    input  logic          b_wr_en,
    input  logic          b_rd_en,
    input  logic [W-1:0]  b_wr_data,
    output logic [W-1:0]  b_rd_data
);

    logic                a_tx_wr, a_rx_rd, b_tx_wr, b_rx_rd;
    logic [IW-1:0]       a_tx_idx, a_rx_idx, b_tx_idx, b_rx_idx;
    logic [W-1:0]        a_tx_word, b_tx_word;
    logic [N-1:0][W-1:0] ab_data, ba_data;
    logic [N-1:0]        ab_full, ba_full;

    mbx_side #(.N(N), .W(W), .AW(AW)) u_side_a (
        .clk(clk), .rst_n(rst_n),
        .addr(a_addr), .wr_en(a_wr_en), .rd_en(a_rd_en), .wr_data(a_wr_data),
        .rx_data(ba_data), .rx_full(ba_full), .tx_full(ab_full),
        .rd_data(a_rd_data),
        .tx_wr(a_tx_wr), .tx_idx(a_tx_idx), .tx_word(a_tx_word),
        .rx_rd(a_rx_rd), .rx_idx(a_rx_idx)
    );

    mbx_side #(.N(N), .W(W), .AW(AW)) u_side_b (
        .clk(clk), .rst_n(rst_n),
        .addr(b_addr), .wr_en(b_wr_en), .rd_en(b_rd_en), .wr_data(b_wr_data),
        .rx_data(ab_data), .rx_full(ab_full), .tx_full(ba_full),
        .rd_data(b_rd_data),
        .tx_wr(b_tx_wr), .tx_idx(b_tx_idx), .tx_word(b_tx_word),
        .rx_rd(b_rx_rd), .rx_idx(b_rx_idx)
    );

    // A to B
    mbx_channel #(.N(N), .W(W)) u_chan_ab (
        .clk(clk), .rst_n(rst_n),
        .wr_en(a_tx_wr), .wr_idx(a_tx_idx), .wr_data(a_tx_word),
        .rd_en(b_rx_rd), .rd_idx(b_rx_idx),
        .slot_data(ab_data), .slot_full(ab_full)
    );

    // B to A
    mbx_channel #(.N(N), .W(W)) u_chan_ba (
        .clk(clk), .rst_n(rst_n),
        .wr_en(b_tx_wr), .wr_idx(b_tx_idx), .wr_data(b_tx_word),
        .rd_en(a_rx_rd), .rd_idx(a_rx_idx),
        .slot_data(ba_data), .slot_full(ba_full)
    );

endmodule

// File: tb/mbx_dual_bench.sv
`timescale 1ns/1ps
module mbx_dual_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  a_addr = '0, b_addr = '0;
    logic        a_wr_en = 1'b0, a_rd_en = 1'b0, b_wr_en = 1'b0, b_rd_en = 1'b0;
    logic [31:0] a_wr_data = '0, b_wr_data = '0;
    logic [31:0] a_rd_data, b_rd_data;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    // model: index = receiving side (0 = A, 1 = B)
    logic [31:0] exp_data [2][4];
    bit          exp_full [2][4];

    always #2 clk = ~clk;

    mbx_dual u_mbx_dual (
        .clk(clk), .rst_n(rst_n),
        .a_addr(a_addr), .a_wr_en(a_wr_en), .a_rd_en(a_rd_en),
        .a_wr_data(a_wr_data), .a_rd_data(a_rd_data),
        .b_addr(b_addr), .b_wr_en(b_wr_en), .b_rd_en(b_rd_en),
        .b_wr_data(b_wr_data), .b_rd_data(b_rd_data)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] stat_exp(input int s);
        logic [31:0] v = '0;
        for (int n = 0; n < 4; n++) begin
            v[7-n] = !exp_full[1-s][n];
            v[3-n] = exp_full[s][n];
        end
        return v;
    endfunction

    task automatic drive(input int s, input logic we, input logic re,
                         input logic [2:0] ad, input logic [31:0] wd);
        if (s == 0) begin
            a_wr_en = we; a_rd_en = re; a_addr = ad; a_wr_data = wd;
        end else begin
            b_wr_en = we; b_rd_en = re; b_addr = ad; b_wr_data = wd;
        end
    endtask

    task automatic idle_all();
        drive(0, 1'b0, 1'b0, 3'd0, 32'd0);
        drive(1, 1'b0, 1'b0, 3'd0, 32'd0);
    endtask

    // write to any address; the model is updated only for slot addresses
    task automatic wr(input int s, input logic [2:0] ad, input logic [31:0] v);
        drive(s, 1'b1, 1'b0, ad, v);
        @(negedge clk);
        idle_all();
        if (ad < 3'd4) begin
            exp_data[1-s][ad] = v;
            exp_full[1-s][ad] = 1'b1;
        end
    endtask

    task automatic rd(input int s, input logic [2:0] ad, output logic [31:0] got);
        drive(s, 1'b0, 1'b1, ad, 32'd0);
        @(negedge clk);
        got = (s == 0) ? a_rd_data : b_rd_data;
        idle_all();
    endtask

    task automatic chk_stat(input string req, input int s);
        logic [31:0] g;
        rd(s, 3'd4, g);
        chk(req, g, stat_exp(s));
    endtask

    task automatic chk_slot(input string req, input int s, input int n);
        logic [31:0] g;
        logic [31:0] e;
        e = exp_data[s][n];
        rd(s, 3'(n), g);
        chk(req, g, e);
        exp_full[s][n] = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] g, held, x, y;
        for (int s = 0; s < 2; s++)
            for (int n = 0; n < 4; n++) begin
                exp_data[s][n] = '0;
                exp_full[s][n] = 1'b0;
            end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 rd_data A", a_rd_data, 32'd0);
        chk("R1 rd_data B", b_rd_data, 32'd0);
        chk_stat("R1 R5 status A", 0);
        chk_stat("R1 R5 status B", 1);

        // R2 R3 R5 R9: fill every slot of each side, one at a time
        for (int s = 0; s < 2; s++) begin
            for (int n = 0; n < 4; n++) begin
                wr(s, 3'(n), 32'h1000_0000 * (s + 1) + 32'h0101 * n + 32'h5A);
                chk_stat("R3 R5 sender status", s);
                chk_stat("R3 R9 receiver status", 1 - s);
            end
        end
        // R4 R2: drain every slot, checking word and flags
        for (int s = 0; s < 2; s++) begin
            for (int n = 0; n < 4; n++) begin
                chk_slot("R4 R2 slot word", s, n);
                chk_stat("R4 reader status", s);
                chk_stat("R4 peer status", 1 - s);
            end
        end

        // R4: a read of an empty slot leaves flags alone
        chk_slot("R4 empty slot read", 0, 3);
        chk_stat("R4 empty read status", 0);

        // R6: overwrite of a pending word
        wr(0, 3'd2, 32'hAAAA_0001);
        wr(0, 3'd2, 32'hBBBB_0002);
        chk_stat("R6 sender after overwrite", 0);
        chk_stat("R6 receiver after overwrite", 1);
        chk_slot("R6 newest word kept", 1, 2);
        chk_stat("R6 flags after drain", 0);

        // R7: read and peer write on the same slot in one cycle
        x = 32'hC0DE_0011;
        y = 32'hF00D_0022;
        wr(0, 3'd1, x);
        drive(0, 1'b1, 1'b0, 3'd1, y);
        drive(1, 1'b0, 1'b1, 3'd1, 32'd0);
        @(negedge clk);
        g = b_rd_data;
        idle_all();
        chk("R7 read returns old word", g, x);
        exp_data[1][1] = y;
        exp_full[1][1] = 1'b1;
        chk_stat("R7 full stays set", 1);
        chk_stat("R7 sender empty clear", 0);
        chk_slot("R7 new word kept", 1, 1);

        // R8: writes to status and unused addresses are ignored
        wr(1, 3'd3, 32'h3333_3333);
        wr(0, 3'd4, 32'hFFFF_FFFF);
        wr(0, 3'd5, 32'h1234_5678);
        wr(0, 3'd7, 32'h8765_4321);
        wr(1, 3'd6, 32'hDEAD_BEEF);
        chk_stat("R8 status A after void writes", 0);
        chk_stat("R8 status B after void writes", 1);
        for (int ad = 5; ad < 8; ad++) begin
            rd(0, 3'(ad), g);
            chk("R8 void read zero", g, 32'd0);
        end
        chk_slot("R8 slot word untouched", 0, 3);

        // R10: read data held while idle
        wr(0, 3'd0, 32'h0BAD_CAFE);
        rd(1, 3'd0, held);
        exp_full[1][0] = 1'b0;
        chk("R10 read word", held, 32'h0BAD_CAFE);
        repeat (3) @(negedge clk);
        chk("R10 read data held", b_rd_data, held);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule